// File: doc/BRIEF.md
# Mailbox Interrupt Dual-Port RAM

This block is a synchronous dual-port RAM with two identical, fully independent ports, called left and right. Each port has a chip enable, a write enable, an output enable, an address, a write-data bus and a registered read-data bus. Both ports can reach every word in the same cycle, and both may read the same word at once.

The two highest addresses also serve as mailboxes between the two ports. The highest word belongs to the right port. When the left port writes that word, the right port's active-low interrupt output goes low. It returns high when the right port reads the same word. The word one below the top belongs to the left port and works the other way round.

The mailbox byte is stored like any other word, and software gives it its meaning. Both interrupt outputs are driven at every moment. The depth follows from `ADDR_W`. The default is 10 address bits (1024 words), which keeps elaboration small. Setting it to 13 gives 8192 words, with the mailboxes at 0x1FFE and 0x1FFF.

Top module: `mbox_dpram`

## Requirements
- R1: A port whose chip enable and write enable are both high at a rising clock edge stores its write data at its address.
- R2: A port whose chip enable and output enable are high and whose write enable is low at an edge performs a read. Its read-data output shows the stored word after that edge. In every other cycle the read-data output holds its value.
- R3: The two ports work independently. Both may read the same word in the same cycle and get the same value. Each may write a different word in the same cycle.
- R4: A read of a word that the other port writes in the same cycle returns the old contents. The new value is returned from the next cycle on.
- R5: When both ports write the same word in the same cycle, the left port's data is kept.
- R6: A left-port write to the top address (all address bits one; 0x3FF by default) drives `r_irq_n` low after that edge.
- R7: A right-port read of the top address drives `r_irq_n` high after that edge.
- R8: A right-port write to the top address minus one (0x3FE by default) drives `l_irq_n` low after that edge.
- R9: A left-port read of the top address minus one drives `l_irq_n` high after that edge.
- R10: If a flag is set and cleared in the same cycle, it ends up set, so its output is low.
- R11: During and after reset, both interrupt outputs are high and both read-data outputs are zero.
- R12: A mailbox word keeps the byte written to it, and that byte can be read back like any other word.
- R13: An access with chip enable low stores nothing and sets no flag. A cycle with output enable low reads nothing and clears no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce | input | 1 | Left chip enable, active high |
| l_we | input | 1 | Left write enable, active high |
| l_oe | input | 1 | Left output (read) enable, active high |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low, always driven |
| r_ce | input | 1 | Right chip enable, active high |
| r_we | input | 1 | Right write enable, active high |
| r_oe | input | 1 | Right output (read) enable, active high |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low, always driven |

## Verification
Two functions can fall in the same cycle: one port writes a mailbox while the owning port reads that same mailbox. That one edge both sets and clears the flag, and it is also a read of a word being written. The bench provokes it by driving the left write of the top address and the right read of the top address together. It then requires `r_irq_n` to be low after the edge and the right read data to show the byte that was there before. A second, separate right read must then release the interrupt and return the new byte.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Decoded access of one port for one clock edge.
  typedef struct packed {
    logic wr;        // store write data
    logic rd;        // capture read data
    logic clr_own;   // read of this port's own mailbox
    logic set_peer;  // write of the other port's mailbox
  } port_dec_t;

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] OWN_BOX  = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              ce,
  input  logic              we,
  input  logic              oe,
  input  logic [ADDR_W-1:0] addr,
  output port_dec_t         dec
);

  always_comb begin
    dec.wr       = ce & we;
    dec.rd       = ce & oe & ~we;
    dec.clr_own  = dec.rd && (addr == OWN_BOX);
    dec.set_peer = dec.wr && (addr == PEER_BOX);
  end

endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n)     pending <= 1'b0;
    else if (set)   pending <= 1'b1;
    else if (clr)   pending <= 1'b0;
  end

  assign irq_n = ~pending;

  AST_SET_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n); // R10
  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n)); // R13

endmodule

// File: rtl/mbox_mem.sv
module mbox_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_l,
  input  logic              rd_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] q_l,
  input  logic              wr_r,
  input  logic              rd_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] q_r
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Left write is applied last, so it wins a same-word collision.
  always_ff @(posedge clk) begin
    if (wr_r) mem[addr_r] <= din_r;
    if (wr_l) mem[addr_l] <= din_l;
  end

  // Non-blocking reads see the contents from before this edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_l <= '0;
      q_r <= '0;
    end else begin
      if (rd_l) q_l <= mem[addr_l];
      if (rd_r) q_r <= mem[addr_r];
    end
  end

  AST_LEFT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_l |=> mem[$past(addr_l)] == $past(din_l)); // R1
  AST_RIGHT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_r && !(wr_l && addr_l == addr_r)) |=> mem[$past(addr_r)] == $past(din_r)); // R1
  AST_COLLIDE_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_l && wr_r && addr_l == addr_r) |=> mem[$past(addr_l)] == $past(din_l)); // R5
  AST_OLD_ON_CROSS_L: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_l && wr_r && addr_l == addr_r) |=> q_l == $past(mem[addr_l])); // R4
  AST_OLD_ON_CROSS_R: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_r && wr_l && addr_l == addr_r) |=> q_r == $past(mem[addr_r])); // R4
  AST_HOLD_Q_L: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_l |=> $stable(q_l)); // R2
  AST_HOLD_Q_R: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_r |=> $stable(q_r)); // R2

endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] BOX_R = '1;            // owned by right port
  localparam logic [ADDR_W-1:0] BOX_L = BOX_R - 1'b1;  // owned by left port

  // Side 0 is left, side 1 is right.
  logic              ce_v   [2];
  logic              we_v   [2];
  logic              oe_v   [2];
  logic [ADDR_W-1:0] addr_v [2];
  port_dec_t         dec_v  [2];
  logic              irq_v  [2];

  assign ce_v[0] = l_ce;   assign ce_v[1] = r_ce;
  assign we_v[0] = l_we;   assign we_v[1] = r_we;
  assign oe_v[0] = l_oe;   assign oe_v[1] = r_oe;
  assign addr_v[0] = l_addr; assign addr_v[1] = r_addr;

  for (genvar s = 0; s < 2; s++) begin : g_side
    mbox_port_dec #(
      .ADDR_W  (ADDR_W),
      .OWN_BOX (s == 0 ? BOX_L : BOX_R),
      .PEER_BOX(s == 0 ? BOX_R : BOX_L)
    ) i_dec (
      .ce  (ce_v[s]),
      .we  (we_v[s]),
      .oe  (oe_v[s]),
      .addr(addr_v[s]),
      .dec (dec_v[s])
    );

    mbox_flag i_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (dec_v[1-s].set_peer),
      .clr  (dec_v[s].clr_own),
      .irq_n(irq_v[s])
    );
  end

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  mbox_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_l  (dec_v[0].wr),
    .rd_l  (dec_v[0].rd),
    .addr_l(l_addr),
    .din_l (l_wdata),
    .q_l   (l_rdata),
    .wr_r  (dec_v[1].wr),
    .rd_r  (dec_v[1].rd),
    .addr_r(r_addr),
    .din_r (r_wdata),
    .q_r   (r_rdata)
  );

  AST_RIGHT_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(r_irq_n) |-> $past(l_ce && l_we && l_addr == BOX_R)); // R6
  AST_LEFT_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l_irq_n) |-> $past(r_ce && r_we && r_addr == BOX_L)); // R8
  AST_RIGHT_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_irq_n) |-> $past(r_ce && r_oe && !r_we && r_addr == BOX_R)); // R7
  AST_LEFT_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l_irq_n) |-> $past(l_ce && l_oe && !l_we && l_addr == BOX_L)); // R9

endmodule

// File: tb/test_mbox_dpram.sv
module test_mbox_dpram;

  localparam int unsigned AW = 10;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] TOP   = '1;
  localparam logic [AW-1:0] TOPM1 = TOP - 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_ce = 0, l_we = 0, l_oe = 0, r_ce = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) i_mbox_dpram (
    .clk(clk), .rst_n(rst_n),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic pl(input logic ce, input logic we, input logic oe,
                    input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
  endtask

  task automatic pr(input logic ce, input logic we, input logic oe,
                    input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
  endtask

  // One edge with the driven inputs, then back to idle at the falling edge.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    pl(0, 0, 0, '0, '0);
    pr(0, 0, 0, '0, '0);
  endtask

  task automatic t_reset();
    check("R11 l_irq_n", {7'd0, l_irq_n}, 8'h01);
    check("R11 r_irq_n", {7'd0, r_irq_n}, 8'h01);
    check("R11 l_rdata", l_rdata, 8'h00);
    check("R11 r_rdata", r_rdata, 8'h00);
  endtask

  task automatic t_basic();
    pl(1, 1, 0, 10'h010, 8'hA5); step();
    pl(1, 0, 1, 10'h010, 8'h00); step();
    check("R1/R2 left read back", l_rdata, 8'hA5);
    pr(1, 0, 1, 10'h010, 8'h00); step();
    check("R3 right sees left write", r_rdata, 8'hA5);
    pl(1, 0, 0, 10'h011, 8'h00); step();
    check("R2 hold without oe", l_rdata, 8'hA5);
  endtask

  task automatic t_parallel();
    pl(1, 0, 1, 10'h010, 8'h00); pr(1, 0, 1, 10'h010, 8'h00); step();
    check("R3 both read left", l_rdata, 8'hA5);
    check("R3 both read right", r_rdata, 8'hA5);
    pl(1, 1, 0, 10'h021, 8'hC3); pr(1, 1, 0, 10'h020, 8'h3C); step();
    pl(1, 0, 1, 10'h020, 8'h00); pr(1, 0, 1, 10'h021, 8'h00); step();
    check("R3 left reads right word", l_rdata, 8'h3C);
    check("R3 right reads left word", r_rdata, 8'hC3);
  endtask

  task automatic t_cross();
    pr(1, 1, 0, 10'h010, 8'h5A); pl(1, 0, 1, 10'h010, 8'h00); step();
    check("R4 old data on cross read", l_rdata, 8'hA5);
    pl(1, 0, 1, 10'h010, 8'h00); step();
    check("R4 new data next cycle", l_rdata, 8'h5A);
  endtask

  task automatic t_collide();
    pl(1, 1, 0, 10'h030, 8'h11); pr(1, 1, 0, 10'h030, 8'h22); step();
    pr(1, 0, 1, 10'h030, 8'h00); step();
    check("R5 left wins collision", r_rdata, 8'h11);
  endtask

  task automatic t_mail_right();
    pl(1, 1, 0, TOP, 8'h77); step();
    check("R6 r_irq_n low", {7'd0, r_irq_n}, 8'h00);
    check("R6 l_irq_n untouched", {7'd0, l_irq_n}, 8'h01);
    pr(1, 0, 0, TOP, 8'h00); step();
    check("R13 no oe keeps flag", {7'd0, r_irq_n}, 8'h00);
    pr(1, 0, 1, TOP, 8'h00); step();
    check("R12 mailbox byte", r_rdata, 8'h77);
    check("R7 r_irq_n released", {7'd0, r_irq_n}, 8'h01);
  endtask

  task automatic t_mail_left();
    pr(1, 1, 0, TOPM1, 8'h88); step();
    check("R8 l_irq_n low", {7'd0, l_irq_n}, 8'h00);
    pl(1, 0, 1, TOPM1, 8'h00); step();
    check("R12 left mailbox byte", l_rdata, 8'h88);
    check("R9 l_irq_n released", {7'd0, l_irq_n}, 8'h01);
  endtask

  task automatic t_set_wins();
    pl(1, 1, 0, TOP, 8'h99); step();
    pl(1, 1, 0, TOP, 8'hAA); pr(1, 0, 1, TOP, 8'h00); step();
    check("R10 set beats clear", {7'd0, r_irq_n}, 8'h00);
    check("R4 old mailbox byte", r_rdata, 8'h99);
    pr(1, 0, 1, TOP, 8'h00); step();
    check("R7 later read releases", {7'd0, r_irq_n}, 8'h01);
    check("R12 new mailbox byte", r_rdata, 8'hAA);
  endtask

  task automatic t_no_ce();
    pl(0, 1, 0, TOP, 8'h55); step();
    check("R13 no ce no flag", {7'd0, r_irq_n}, 8'h01);
    pr(1, 0, 1, TOP, 8'h00); step();
    check("R13 no ce no store", r_rdata, 8'hAA);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_parallel();
    t_cross();
    t_collide();
    t_mail_right();
    t_mail_left();
    t_set_wins();
    t_no_ce();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule